// File: doc/BRIEF.md
# SPI Flash Controller Status Register

This block is the 16-bit status word of a host-side SPI flash controller. It follows one programmed flash cycle from the moment software strikes the start strobe until the shifter reports completion. It exposes a busy flag and a completion flag, and it latches a sticky flag whenever an access is refused. An access is refused when a protection check rejects it, when software rewrites a cycle-programming register during a cycle, or when software issues a second start while a cycle is still running.

The register also holds a write-once lock bit. The lock drives an output that the static configuration registers use to refuse writes, and only a hardware reset clears it. After reset, the controller polls the flash status register. During that polling the busy flag reads 1. When polling completes, busy drops and the completion flag rises. While the completion flag is set and the interrupt enable input is high, a system-management interrupt request is raised.

The read port is combinational from the flops. A hardware set event takes priority over a software write-one-to-clear that lands in the same cycle.

Top module: `spi_stat_reg`

## Requirements
- R1: After reset the read value is 0x0001. Bits 14:4 and bit 1 always read 0.
- R2: Writing 1 to bit 15 sets the lock. Writing 0 does not clear it, and only reset clears it. `cfg_lock` equals bit 15.
- R3: A `go` pulse while bit 0 is 0 (and polling is over) sets bit 0 on the next cycle.
- R4: `cyc_cmplt` while a programmed cycle is busy clears bit 0 and sets bit 2 on the next cycle.
- R5: Bits 3 and 2 are write-one-to-clear. Writing 0 to them leaves them unchanged.
- R6: `blk_evt` sets bit 3 on the next cycle.
- R7: `prog_wr` or `go` while bit 0 is 1 sets bit 3. Such a `go` does not start a new cycle, so a later single `cyc_cmplt` ends the busy state.
- R8: `smi_req` is high exactly when bit 2 is 1 and `smi_en` is 1.
- R9: From reset until `poll_done`, bit 0 reads 1 and bit 2 reads 0. On `poll_done`, bit 0 clears and bit 2 sets. `cyc_cmplt` during polling has no effect, and `go` during polling sets bit 3.
- R10: A hardware set of bit 2 or bit 3 in the same cycle as a software clear of that bit leaves the bit at 1.
- R11: Writes to bit 0 and to the reserved bits do not change the read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| go | input | 1 | Start-cycle strobe |
| cyc_cmplt | input | 1 | Programmed cycle completed on the bus |
| blk_evt | input | 1 | Access refused by protection policy |
| prog_wr | input | 1 | A cycle-programming register was written |
| poll_done | input | 1 | Post-reset status polling finished |
| smi_en | input | 1 | Interrupt enable for cycle completion |
| smi_req | output | 1 | Interrupt request |
| cfg_lock | output | 1 | Static configuration lock |

## Verification
Two situations can fall in the same cycle and are provoked on purpose.

The first is a hardware set of the done or blocked flag together with a software write-one-to-clear of that flag. The bench drives `cyc_cmplt` or `blk_evt` on the same edge as a clearing write. It expects the flag to read 1 afterwards.

The second is a `go` strobe that lands on the same edge as `cyc_cmplt` of the running cycle. The bench expects the cycle to finish, busy to fall, and the blocked flag to rise, because the strobe was judged against the busy state before that edge. Random traffic mixes these events freely, and a bench reference model updated from the requirements judges every cycle.

// File: rtl/spi_stat_reg.sv
module spi_stat_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        go,
  input  logic        cyc_cmplt,
  input  logic        blk_evt,
  input  logic        prog_wr,
  input  logic        poll_done,
  input  logic        smi_en,
  output logic        smi_req,
  output logic        cfg_lock
);

  logic lock_q, blk_q, done_q, busy_q, poll_q;

  wire start    = go && !busy_q;
  wire finish   = busy_q && !poll_q && cyc_cmplt;
  wire poll_end = poll_q && poll_done;
  wire blk_set  = blk_evt || (busy_q && (prog_wr || go));
  wire done_set = finish || poll_end;
  wire blk_clr  = reg_wr && reg_wdata[3];
  wire done_clr = reg_wr && reg_wdata[2];

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[14:4], reg_wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      blk_q  <= 1'b0;
      done_q <= 1'b0;
      busy_q <= 1'b1;
      poll_q <= 1'b1;
    end else begin
      if (reg_wr && reg_wdata[15]) lock_q <= 1'b1;
      if (blk_set)                 blk_q  <= 1'b1;
      else if (blk_clr)            blk_q  <= 1'b0;
      if (done_set)                done_q <= 1'b1;
      else if (done_clr)           done_q <= 1'b0;
      if (poll_end || finish)      busy_q <= 1'b0;
      else if (start)              busy_q <= 1'b1;
      if (poll_end)                poll_q <= 1'b0;
    end
  end

  assign reg_rdata = {lock_q, 11'b0, blk_q, done_q, 1'b0, busy_q};
  assign smi_req   = done_q && smi_en;
  assign cfg_lock  = lock_q;

endmodule

module spi_stat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] reg_rdata,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic        go,
  input logic        cyc_cmplt,
  input logic        blk_evt,
  input logic        smi_en,
  input logic        smi_req,
  input logic        cfg_lock,
  input logic        poll
);

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> cfg_lock);

  // R3
  go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !reg_rdata[0]) |=> reg_rdata[0]);

  // R4
  cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cmplt && reg_rdata[0] && !poll) |=> (!reg_rdata[0] && reg_rdata[2]));

  // R6
  blk_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_evt |=> reg_rdata[3]);

  // R7
  go_busy_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && reg_rdata[0]) |=> reg_rdata[3]);

  // R8
  smi_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req == (reg_rdata[2] && smi_en));

  // R9
  poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll |-> (reg_rdata[0] && !reg_rdata[2]));

  // R5
  w1c_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[2] && !cyc_cmplt && !poll) |=> !reg_rdata[2]);

endmodule

bind spi_stat_reg spi_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .go(go), .cyc_cmplt(cyc_cmplt), .blk_evt(blk_evt),
  .smi_en(smi_en), .smi_req(smi_req), .cfg_lock(cfg_lock), .poll(poll_q)
);

// File: tb/spi_stat_reg_bench.sv
module spi_stat_reg_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, go = 0, cyc_cmplt = 0, blk_evt = 0, prog_wr = 0;
  logic poll_done = 0, smi_en = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic smi_req, cfg_lock;
  int total = 0, bad = 0;
  logic m_lock, m_blk, m_done, m_busy, m_poll;

  always #10 clk = ~clk;

  spi_stat_reg u_spi_stat_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .go(go), .cyc_cmplt(cyc_cmplt), .blk_evt(blk_evt),
    .prog_wr(prog_wr), .poll_done(poll_done), .smi_en(smi_en),
    .smi_req(smi_req), .cfg_lock(cfg_lock));

  function automatic logic [15:0] model_word();
    return {m_lock, 11'b0, m_blk, m_done, 1'b0, m_busy};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lock = 0; m_blk = 0; m_done = 0; m_busy = 1; m_poll = 1;
  endtask

  task automatic model_step();
    logic fin, pend, bset, dset;
    fin  = m_busy && !m_poll && cyc_cmplt;
    pend = m_poll && poll_done;
    bset = blk_evt || (m_busy && (prog_wr || go));
    dset = fin || pend;
    if (reg_wr && reg_wdata[15]) m_lock = 1;
    if (bset) m_blk = 1; else if (reg_wr && reg_wdata[3]) m_blk = 0;
    if (dset) m_done = 1; else if (reg_wr && reg_wdata[2]) m_done = 0;
    if (pend || fin) m_busy = 0; else if (go && !m_busy) m_busy = 1;
    if (pend) m_poll = 0;
  endtask

  task automatic step(input string req);
    model_step();
    @(posedge clk); #1;
    check({req, " word"}, reg_rdata, model_word());
    check("R8 smi", {15'b0, smi_req}, {15'b0, m_done && smi_en});
    check("R2 lock", {15'b0, cfg_lock}, {15'b0, m_lock});
    @(negedge clk);
    {reg_wr, reg_wdata, go, cyc_cmplt, blk_evt, prog_wr, poll_done} = '0;
  endtask

  task automatic do_reset();
    rst_n = 0; model_reset();
    @(negedge clk); #1;
    check("R1 reset", reg_rdata, 16'h0001);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    // R9 polling: cyc_cmplt ignored, go blocked
    cyc_cmplt = 1; step("R9 cmplt during poll");
    go = 1; step("R9 go during poll");
    reg_wr = 1; reg_wdata = 16'h0008; step("R5 clear blk");
    poll_done = 1; step("R9 poll end");
    check("R9 done after poll", reg_rdata & 16'h0005, 16'h0004);
    smi_en = 1; #1; check("R8 smi high", {15'b0, smi_req}, 16'h0001);
    smi_en = 0;
    // R11 writes to RO/reserved
    reg_wr = 1; reg_wdata = 16'h7FF3 & ~16'h000C; step("R11 ro write");
    reg_wr = 1; reg_wdata = 16'h0000; step("R5 write zero");
    check("R5 done held", reg_rdata & 16'h0004, 16'h0004);
    reg_wr = 1; reg_wdata = 16'h0004; step("R5 clear done");
    // R3, R7
    go = 1; step("R3 start");
    check("R3 busy", reg_rdata & 16'h0001, 16'h0001);
    go = 1; prog_wr = 1; step("R7 go while busy");
    check("R7 blk", reg_rdata & 16'h0008, 16'h0008);
    // R4 plus go on the same edge
    cyc_cmplt = 1; go = 1; step("R4 finish");
    check("R4 idle done", reg_rdata & 16'h0005, 16'h0004);
    // R10 set wins
    go = 1; step("R3 start2");
    cyc_cmplt = 1; blk_evt = 1; reg_wr = 1; reg_wdata = 16'h000C; step("R10 set wins");
    check("R10 flags", reg_rdata & 16'h000C, 16'h000C);
    // R6
    reg_wr = 1; reg_wdata = 16'h0008; step("R5 clr");
    blk_evt = 1; step("R6 blk event");
    // R2
    reg_wr = 1; reg_wdata = 16'h8000; step("R2 set lock");
    reg_wr = 1; reg_wdata = 16'h0000; step("R2 no clear");
    check("R2 held", reg_rdata & 16'h8000, 16'h8000);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      go        = ($urandom % 6) == 0;
      cyc_cmplt = ($urandom % 4) == 0;
      blk_evt   = ($urandom % 12) == 0;
      prog_wr   = ($urandom % 10) == 0;
      poll_done = ($urandom % 8) == 0;
      smi_en    = $urandom % 2;
      reg_wr    = ($urandom % 5) == 0;
      reg_wdata = 16'($urandom) & (($urandom % 20) == 0 ? 16'hFFFF : 16'h7FFF);
      step("R4 R7 random");
      if (($urandom % 500) == 0) do_reset();
    end
    do_reset();
    check("R2 reset clears lock", {15'b0, cfg_lock}, 16'h0000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule